// File: doc/BRIEF.md
# Serial EEPROM Boot Loader with Address and Rate Fallback

This block runs once after reset. It takes sole ownership of a two-wire bus as the only master and looks for an external serial EEPROM. The first probe uses the preferred device address at the slow bus rate. Each probe that is not acknowledged is followed by a retry at the next address of an eight-address window, at the fast rate. When a device answers, the block reads the image from memory offset zero in a single sequential transfer. It checks the leading header byte against a parameter value. It then delivers every following byte to an internal byte-write port, tagged with its memory address.

When loading finishes, or when no usable image exists, the block stops driving the bus for good. It raises `done` and, at the same time, switches to slave-only operation at a fixed slave address. If no device answered or the header did not match, `useRom` is raised as well, which tells the system to run the built-in firmware. The bus pins are open-drain: `sclOe` and `sdaOe` pull the lines low when high, and `sdaIn` returns the resolved data line.

Top module: `i2cBootLoader`

## Requirements
- R1: After reset the first probe is a START followed by device address 0x52 with the write bit (0). It runs at the slow rate, an SCL period of 4*floor(SYS_CLK_HZ/(4*SLOW_HZ)) clocks.
- R2: A probe that gets no acknowledge on its device or word-address bytes is ended with a STOP. It is retried at 0x50, 0x51, 0x53, 0x54, 0x55, 0x56, 0x57 in that order, each at the fast rate, an SCL period of 4*floor(SYS_CLK_HZ/(4*FAST_HZ)) clocks.
- R3: An answering device is read with: START, device+write, word address high byte 0x00, word address low byte 0x00, repeated START, device+read, then IMG_BYTES sequential bytes. The master acknowledges every byte except the last, which gets a NACK, and a STOP follows. SDA changes only while SCL is low, except at START and STOP.
- R4: When byte 0 equals HEADER, bytes 1..IMG_BYTES-1 each give exactly one `wrEn` pulse, in ascending order, with `wrAddr` equal to the memory address and `wrData` the byte read. Address 0 is never written, and `useRom` stays 0.
- R5: When byte 0 differs from HEADER, the master NACKs that byte and sends a STOP. It then finishes with `useRom`=1 and no `wrEn` pulse.
- R6: When none of the eight addresses acknowledges, the block finishes with `useRom`=1 and no `wrEn` pulse.
- R7: During reset `sclOe`, `sdaOe`, `wrEn`, `done`, `useRom` and `slaveEn` are all 0.
- R8: Once `done` is 1, it stays 1 until reset, `sclOe` and `sdaOe` stay 0, `slaveEn` is 1 and `slaveAddr` is 0x39.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, restarts the boot sequence |
| sdaIn | input | 1 | Resolved level of the bus data line |
| sclOe | output | 1 | Pull the bus clock line low when 1 |
| sdaOe | output | 1 | Pull the bus data line low when 1 |
| wrEn | output | 1 | One-cycle strobe for a loaded firmware byte |
| wrAddr | output | ADDR_W | Memory address of the loaded byte |
| wrData | output | 8 | Loaded byte value |
| done | output | 1 | Boot sequence finished, bus released |
| useRom | output | 1 | No valid external image, run internal firmware |
| slaveEn | output | 1 | Slave-only mode enabled |
| slaveAddr | output | 7 | Fixed slave address used after loading |

## Verification
The bench builds the block with SYS_CLK_HZ of 2.4 MHz, so the quarter-bit divisors are 6 at the slow rate and 2 at the fast rate, and with a six-byte image and header 0xA5. A memory model that can sit at any address of the window lets the bench sweep all eight positions, plus the cases of no device and a bad header. This makes every length of the retry chain reachable in a short run: from one probe up to all eight. The model records each probe's address and measured SCL period, the word pointer, how many bytes it sent and whether the last one was NACKed. These records are compared with values computed from the fallback order.

// File: rtl/bootPkg.sv
package bootPkg;
  typedef enum logic [1:0] {OP_START, OP_STOP, OP_WRITE, OP_READ} busOpT;

  // strobes from control to the bit engine
  typedef struct packed {
    logic       go;
    busOpT      op;
    logic [7:0] tx;
    logic       fast;
    logic       ack;   // drive ACK in the read ack slot
  } busCmdT;

  typedef struct packed {
    logic       opDone;
    logic       ackIn;   // slave pulled SDA low in the ack slot
    logic [7:0] rxByte;
  } busStatT;
endpackage

// File: rtl/bootBitEngine.sv
module bootBitEngine
  import bootPkg::*;
#(
  parameter int Q_SLOW = 125,
  parameter int Q_FAST = 41
) (
  input  logic    clk,
  input  logic    rstN,
  input  busCmdT  cmd,
  input  logic    sdaIn,
  output busStatT stat,
  output logic    sclOe,
  output logic    sdaOe
);
  localparam int QW = $clog2(Q_SLOW + 1);

  logic          busy, fastQ, ackQ, doneQ;
  busOpT         op;
  logic [1:0]    phase;
  logic [3:0]    slot;
  logic [QW-1:0] qCnt, qMax;
  logic [7:0]    txSh, rxSh;
  logic          sdaMeta, sdaSync;
  logic          isByte, lastSlot, qEnd, nxtScl, nxtSda;

  assign isByte   = (op == OP_WRITE) || (op == OP_READ);
  assign lastSlot = isByte ? (slot == 4'd8) : (slot == 4'd0);
  assign qMax     = fastQ ? QW'(Q_FAST - 1) : QW'(Q_SLOW - 1);
  assign qEnd     = (qCnt == qMax);

  // line drive per quarter phase; 1 = pull low
  always_comb begin
    nxtScl = (phase == 2'd0) || (phase == 2'd3);
    nxtSda = 1'b0;
    case (op)
      OP_START: nxtSda = (phase >= 2'd2);
      OP_STOP: begin
        nxtScl = (phase == 2'd0);
        nxtSda = (phase <= 2'd1);
      end
      OP_WRITE: nxtSda = (slot < 4'd8) ? !txSh[3'd7 - slot[2:0]] : 1'b0;
      default:  nxtSda = (slot == 4'd8) ? cmd.ack : 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0; fastQ <= 1'b0; ackQ <= 1'b0; doneQ <= 1'b0;
      op <= OP_STOP; phase <= '0; slot <= '0; qCnt <= '0;
      txSh <= '0; rxSh <= '0; sclOe <= 1'b0; sdaOe <= 1'b0;
      sdaMeta <= 1'b1; sdaSync <= 1'b1;
    end else begin
      sdaMeta <= sdaIn;
      sdaSync <= sdaMeta;
      doneQ   <= 1'b0;
      if (!busy) begin
        if (cmd.go) begin
          busy <= 1'b1; op <= cmd.op; txSh <= cmd.tx; fastQ <= cmd.fast;
          phase <= '0; slot <= '0; qCnt <= '0;
        end
      end else begin
        sclOe <= nxtScl;
        sdaOe <= nxtSda;
        if (isByte && phase == 2'd2 && qCnt == '0) begin
          if (slot < 4'd8) rxSh <= {rxSh[6:0], sdaSync};
          else             ackQ <= !sdaSync;
        end
        if (qEnd) begin
          qCnt  <= '0;
          phase <= phase + 2'd1;
          if (phase == 2'd3) begin
            if (lastSlot) begin
              busy  <= 1'b0;
              doneQ <= 1'b1;
            end else slot <= slot + 4'd1;
          end
        end else qCnt <= qCnt + QW'(1);
      end
    end
  end

  assign stat = '{opDone: doneQ, ackIn: ackQ, rxByte: rxSh};

  AST_SDA_MOVES_WITH_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaOe) && !sclOe && !$past(sclOe)) |-> (op == OP_START || op == OP_STOP)); // R3
endmodule

// File: rtl/bootCtrl.sv
module bootCtrl
  import bootPkg::*;
#(
  parameter int         ADDR_W    = 13,
  parameter int         IMG_BYTES = 8192,
  parameter logic [7:0] HEADER    = 8'hA5,
  parameter logic [6:0] DEV_BASE  = 7'h50,
  parameter logic [6:0] DEV_FIRST = 7'h52,
  parameter int         DEV_SPAN  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStatT           stat,
  output busCmdT            cmd,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic              done,
  output logic              useRom
);
  localparam int TRY_W     = $clog2(DEV_SPAN);
  localparam int FIRST_OFF = int'(DEV_FIRST) - int'(DEV_BASE);
  localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(DEV_SPAN - 1);
  localparam logic [ADDR_W-1:0] LAST_RD = ADDR_W'(IMG_BYTES - 1);

  typedef enum logic [3:0] {
    C_START1, C_DEVW, C_AHI, C_ALO, C_START2, C_DEVR, C_READ, C_STOP, C_END
  } ctrlStT;
  typedef enum logic [1:0] {RES_NACK, RES_OK, RES_BAD} resT;

  ctrlStT            state;
  resT               res;
  logic              pend, goQ;
  busOpT             opQ, opNext;
  logic [7:0]        txQ, txNext;
  logic [TRY_W-1:0]  tryIdx;
  logic [ADDR_W-1:0] rdCnt;
  logic [6:0]        devSel;
  logic              lastRd, hdrBad;

  // probe order: preferred address, then the rest of the window ascending
  always_comb begin
    if (tryIdx == '0)                   devSel = DEV_FIRST;
    else if (int'(tryIdx) <= FIRST_OFF) devSel = DEV_BASE + 7'(tryIdx) - 7'd1;
    else                                devSel = DEV_BASE + 7'(tryIdx);
  end

  always_comb begin
    case (state)
      C_START1, C_START2: opNext = OP_START;
      C_STOP, C_END:      opNext = OP_STOP;
      C_READ:             opNext = OP_READ;
      default:            opNext = OP_WRITE;
    endcase
    case (state)
      C_DEVW:  txNext = {devSel, 1'b0};
      C_DEVR:  txNext = {devSel, 1'b1};
      default: txNext = 8'h00;
    endcase
  end

  assign lastRd = (rdCnt == LAST_RD);
  assign hdrBad = (rdCnt == '0) && (stat.rxByte != HEADER);
  assign cmd    = '{go: goQ, op: opQ, tx: txQ, fast: (tryIdx != '0), ack: !lastRd && !hdrBad};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= C_START1; res <= RES_NACK; pend <= 1'b0; goQ <= 1'b0;
      opQ <= OP_START; txQ <= '0; tryIdx <= '0; rdCnt <= '0;
      wrEn <= 1'b0; wrAddr <= '0; wrData <= '0; done <= 1'b0; useRom <= 1'b0;
    end else begin
      goQ  <= 1'b0;
      wrEn <= 1'b0;
      if (state != C_END) begin
        if (!pend) begin
          goQ <= 1'b1; pend <= 1'b1; opQ <= opNext; txQ <= txNext;
        end else if (stat.opDone) begin
          pend <= 1'b0;
          case (state)
            C_START1: state <= C_DEVW;
            C_DEVW:   state <= stat.ackIn ? C_AHI : C_STOP;
            C_AHI:    state <= stat.ackIn ? C_ALO : C_STOP;
            C_ALO:    state <= stat.ackIn ? C_START2 : C_STOP;
            C_START2: state <= C_DEVR;
            C_DEVR: begin
              rdCnt <= '0;
              state <= stat.ackIn ? C_READ : C_STOP;
            end
            C_READ: begin
              if (hdrBad) begin
                res <= RES_BAD; state <= C_STOP;
              end else begin
                if (rdCnt != '0) begin
                  wrEn <= 1'b1; wrAddr <= rdCnt; wrData <= stat.rxByte;
                end
                if (lastRd) begin
                  res <= RES_OK; state <= C_STOP;
                end else rdCnt <= rdCnt + ADDR_W'(1);
              end
            end
            C_STOP: begin
              if (res == RES_OK) begin
                state <= C_END; done <= 1'b1;
              end else if (res == RES_BAD || tryIdx == LAST_TRY) begin
                state <= C_END; done <= 1'b1; useRom <= 1'b1;
              end else begin
                tryIdx <= tryIdx + TRY_W'(1); state <= C_START1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  AST_HEADER_NEVER_WRITTEN: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (wrAddr != '0)); // R4
  AST_ROM_ONLY_WHEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    useRom |-> done); // R6
  AST_DONE_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done); // R8
  AST_NO_WRITE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !wrEn); // R4
endmodule

// File: rtl/i2cBootLoader.sv
module i2cBootLoader
  import bootPkg::*;
#(
  parameter int         SYS_CLK_HZ = 50_000_000,
  parameter int         SLOW_HZ    = 100_000,
  parameter int         FAST_HZ    = 300_000,
  parameter int         ADDR_W     = 13,
  parameter int         IMG_BYTES  = 8192,
  parameter logic [7:0] HEADER     = 8'hA5,
  parameter logic [6:0] DEV_BASE   = 7'h50,
  parameter logic [6:0] DEV_FIRST  = 7'h52,
  parameter int         DEV_SPAN   = 8,
  parameter logic [6:0] SLAVE_ADDR = 7'h39
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic              done,
  output logic              useRom,
  output logic              slaveEn,
  output logic [6:0]        slaveAddr
);
  localparam int Q_SLOW = SYS_CLK_HZ / (4 * SLOW_HZ);
  localparam int Q_FAST = SYS_CLK_HZ / (4 * FAST_HZ);

  busCmdT  cmd;
  busStatT stat;

  bootCtrl #(
    .ADDR_W(ADDR_W), .IMG_BYTES(IMG_BYTES), .HEADER(HEADER),
    .DEV_BASE(DEV_BASE), .DEV_FIRST(DEV_FIRST), .DEV_SPAN(DEV_SPAN)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .stat(stat), .cmd(cmd),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .done(done), .useRom(useRom)
  );

  bootBitEngine #(.Q_SLOW(Q_SLOW), .Q_FAST(Q_FAST)) eng_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .sdaIn(sdaIn), .stat(stat),
    .sclOe(sclOe), .sdaOe(sdaOe)
  );

  assign slaveEn   = done;
  assign slaveAddr = SLAVE_ADDR;

  initial begin
    assert (Q_FAST >= 2 && Q_SLOW >= Q_FAST) else $error("bus rate divisors out of range");
    assert (IMG_BYTES >= 2 && IMG_BYTES <= (1 << ADDR_W)) else $error("image size out of range");
  end

  AST_BUS_RELEASED_WHEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!sclOe && !sdaOe)); // R8
endmodule

// File: tb/i2cBootLoader_tb_top.sv
`timescale 1ns/1ps
module i2cBootLoader_tb_top;
  localparam int SYS_HZ = 2_400_000;
  localparam int SLOW   = 100_000;
  localparam int FAST   = 300_000;
  localparam int IMG    = 6;
  localparam logic [7:0] HDR = 8'hA5;
  localparam longint PER_SLOW = 4 * (SYS_HZ / (4 * SLOW)) * 4;  // ns
  localparam longint PER_FAST = 4 * (SYS_HZ / (4 * FAST)) * 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic sclOe, sdaOe, wrEn, done, useRom, slaveEn;
  logic [12:0] wrAddr;
  logic [7:0]  wrData;
  logic [6:0]  slaveAddr;
  logic slvLow = 1'b0;
  wire sclBus = ~sclOe;
  wire sdaBus = ~(sdaOe | slvLow);

  always #2 clk = ~clk;

  i2cBootLoader #(.SYS_CLK_HZ(SYS_HZ), .SLOW_HZ(SLOW), .FAST_HZ(FAST),
                  .IMG_BYTES(IMG), .HEADER(HDR)) dut_i (
    .clk(clk), .rstN(rstN), .sdaIn(sdaBus), .sclOe(sclOe), .sdaOe(sdaOe),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .done(done),
    .useRom(useRom), .slaveEn(slaveEn), .slaveAddr(slaveAddr));

  int total = 0, bad = 0;
  task automatic chkEq(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // memory model
  logic [7:0] mem [0:63];
  bit slvPresent; logic [6:0] slvAddr;
  bit act = 0, rxM, matched, rdDir, mNack, lastNack;
  int bitN, byteIdx, ptr, wordAddr, sentCnt;
  logic [7:0] sh, txB, ptrHi;
  longint tRise, perNow;
  int attN; int attAddr [0:15]; longint attPer [0:15];

  always @(negedge sdaBus) if (sclBus === 1'b1) begin
    act = 1; rxM = 1; bitN = -1; byteIdx = 0; slvLow = 0;
  end
  always @(posedge sdaBus) if (sclBus === 1'b1) begin
    act = 0; slvLow = 0;
  end
  always @(posedge sclBus) if (act) begin
    if (bitN >= 0 && bitN < 8) begin
      if (rxM) begin
        sh = {sh[6:0], sdaBus};
        if (byteIdx == 0 && bitN == 0) tRise = longint'($time);
        if (byteIdx == 0 && bitN == 1) perNow = longint'($time) - tRise;
      end
    end else if (bitN == 8 && !rxM) mNack = sdaBus;
  end
  always @(negedge sclBus) if (act) begin
    if (bitN == 8) begin
      bitN = 0;
      if (rxM) begin
        if (byteIdx == 0 && !matched) begin act = 0; slvLow = 0; end
        else if (byteIdx == 0 && rdDir) begin
          rxM = 0; mNack = 0; txB = mem[ptr % 64]; ptr++; sentCnt++; slvLow = !txB[7];
        end else begin byteIdx++; slvLow = 0; end
      end else if (mNack) begin
        lastNack = 1; act = 0; slvLow = 0;
      end else begin
        txB = mem[ptr % 64]; ptr++; sentCnt++; slvLow = !txB[7];
      end
    end else begin
      bitN++;
      if (bitN == 8) begin
        if (rxM) begin
          if (byteIdx == 0) begin
            if (!sh[0] && attN < 16) begin attAddr[attN] = int'(sh[7:1]); attPer[attN] = perNow; attN++; end
            matched = slvPresent && (sh[7:1] == slvAddr);
            rdDir = sh[0]; slvLow = matched;
          end else if (byteIdx == 1) begin ptrHi = sh; slvLow = 1; end
          else begin ptr = int'({ptrHi, sh}); wordAddr = ptr; slvLow = 1; end
        end else slvLow = 0;
      end else slvLow = rxM ? 1'b0 : !txB[3'(7 - bitN)];
    end
  end

  // write port monitor
  int wrCnt, wrErr, expNext;
  always @(negedge clk) if (rstN && wrEn) begin
    wrCnt++;
    if (wrAddr != 13'(expNext) || wrData !== mem[wrAddr % 64]) wrErr++;
    expNext++;
  end

  function automatic int expAddr(input int k);
    if (k == 0) return 'h52;
    return 'h50 + ((k - 1) < 2 ? k - 1 : k);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int sc = 0; sc < 10; sc++) begin
      int expCnt, quiet;
      bit good;
      // scenario: 0..7 device at 0x50+sc, 8 none, 9 bad header at 0x52
      slvPresent = (sc != 8);
      slvAddr = (sc == 9) ? 7'h52 : 7'(8'h50 + sc);
      good = (sc < 8);
      for (int i = 0; i < 64; i++) mem[i] = 8'((i * 37 + sc * 11 + 3) & 255);
      mem[0] = (sc == 9) ? 8'h5A : HDR;
      rstN = 1'b0;
      @(negedge clk);
      attN = 0; wrCnt = 0; wrErr = 0; expNext = 1; sentCnt = 0; lastNack = 0;
      wordAddr = -1; act = 0; slvLow = 0;
      repeat (3) @(negedge clk);
      chkEq("R7", "reset bus drive", {sclOe, sdaOe}, 0);
      chkEq("R7", "reset flags", {done, useRom, slaveEn, wrEn}, 0);
      rstN = 1'b1;
      for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
      chkEq("R8", "done reached", done, 1);
      expCnt = 8;
      if (slvPresent) for (int k = 7; k >= 0; k--) if (expAddr(k) == int'(slvAddr)) expCnt = k + 1;
      chkEq(sc == 8 ? "R6" : "R2", "probe count", attN, expCnt);
      for (int k = 0; k < expCnt && k < attN; k++) begin
        chkEq(k == 0 ? "R1" : "R2", "probe address", attAddr[k], expAddr(k));
        chkEq(k == 0 ? "R1" : "R2", "probe SCL period ns", attPer[k], k == 0 ? PER_SLOW : PER_FAST);
      end
      if (good) begin
        chkEq("R3", "word address", wordAddr, 0);
        chkEq("R3", "bytes sent", sentCnt, IMG);
        chkEq("R3", "last byte NACK", lastNack, 1);
        chkEq("R4", "write count", wrCnt, IMG - 1);
        chkEq("R4", "write mismatches", wrErr, 0);
        chkEq("R4", "useRom", useRom, 0);
      end else if (sc == 9) begin
        chkEq("R5", "bytes sent", sentCnt, 1);
        chkEq("R5", "header NACK", lastNack, 1);
        chkEq("R5", "write count", wrCnt, 0);
        chkEq("R5", "useRom", useRom, 1);
      end else begin
        chkEq("R6", "write count", wrCnt, 0);
        chkEq("R6", "useRom", useRom, 1);
      end
      quiet = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (sclBus !== 1'b1 || sdaBus !== 1'b1 || done !== 1'b1) quiet++;
      end
      chkEq("R8", "bus busy cycles after done", quiet, 0);
      chkEq("R8", "slave enable", slaveEn, 1);
      chkEq("R8", "slave address", slaveAddr, 'h39);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule